// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block sits between a register bus and a small on-chip model of a non-volatile word array. Software reads array words directly. Changing the array takes a command that is only accepted in the correct mode. A word write can only clear bits. The stored value becomes the old value ANDed with the new data, so a bit at 0 stays at 0 until an erase. An erase sets bits back to 1, either for one page or for the whole array.

Each accepted command runs for a fixed number of clock cycles, which is set by a parameter. While the command runs, the block drops its ready flag and raises a stall line that holds the requester. A command that arrives at the wrong time or in the wrong mode is discarded. A command that points outside the array is also discarded. In each of these cases a sticky error flag is raised, and software clears it by writing 1 to it.

Bus addresses with the top address bit at 0 select an array word, using the lower bits as the word index. Addresses with the top bit at 1 select a control register, using the two lowest address bits.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the mode register reads 0, the status register reads 1 (ready, no error), stall is low and every array word reads 0xFFFFFFFF.
- R2: The mode register (register offset 0) holds a 2-bit value that reads back as written: 0 = read-only, 1 = write-enable, 2 = erase-enable. The value 3 reads back as 3 and accepts no write or erase command.
- R3: A write to an array word is accepted only in mode 1. In any other mode the word is unchanged, no operation starts, and the error flag is set.
- R4: An accepted word write stores the old word ANDed with the written data. Writing all ones leaves the word unchanged.
- R5: An accepted command holds the ready flag (status bit 0) low for exactly WRITE_CYCLES, PAGE_CYCLES or ALL_CYCLES clock cycles after the accepting edge. The new array contents are readable once ready returns to 1.
- R6: A write of a page index to register offset 2 is accepted only in mode 2. It sets every word of that page to all ones and leaves the other pages unchanged. Pages hold WORDS_PER_PAGE consecutive words. In any other mode it is ignored and sets the error flag.
- R7: Any write to register offset 3 in mode 2 sets every array word to all ones. In any other mode it is ignored and sets the error flag.
- R8: While ready is low, any array write, mode write or erase command is ignored and sets the error flag. The mode register keeps its value.
- R9: A word write to an index of NUM_WORDS or above, or a page erase with an index of NUM_PAGES or above, starts nothing and sets the error flag.
- R10: The error flag (status bit 1) stays set until a write to register offset 1 with bit 1 at 1. A write there with bit 1 at 0 leaves it set.
- R11: The stall output is high exactly while the ready flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Top bit 1 selects a register, 0 selects an array word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| bus_stall | output | 1 | High while a write or erase runs |

## Verification
Word writes are driven with data patterns that partly overlap an already programmed word, and then with all ones. These show whether the result is the AND of old and new data or a plain overwrite. Every command type is issued in each wrong mode, including the undefined value 3, and while an operation runs. Each of these must leave the array untouched and raise the error flag. Page erases use a page next to programmed words in other pages, which separates a correct page decode from one that is off by a page or erases everything. The ready-low stretch is counted for each command type against its own duration.

// File: rtl/nvm_prog_pkg.sv
// Shared encodings for the flash program/erase controller.
// Assumes a 2-bit mode field and a 4-entry register window.
package nvm_prog_pkg;
    localparam logic [1:0] MODE_RO  = 2'd0;
    localparam logic [1:0] MODE_WEN = 2'd1;
    localparam logic [1:0] MODE_EEN = 2'd2;

    localparam logic [1:0] REG_MODE = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_PAGE = 2'd2;
    localparam logic [1:0] REG_ALL  = 2'd3;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_PAGE = 2'd1,
        OP_ALL  = 2'd2
    } nvm_op_e;
endpackage

// File: rtl/nvm_op_timer.sv
// Down-counter that times one flash operation.
// Loads the duration on start and counts down to zero; busy while non-zero.
// Assumes start is raised only while idle and dur is at least 1.
module nvm_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dur,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= dur;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Busy while counting, done in the last busy cycle.
    always_comb begin
        busy = (cnt != '0);
        done = (cnt == CNT_W'(1));
    end

    // R5
    load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == $past(dur)));
    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && busy) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nvm_word_array.sv
// Simulated flash storage: word programming by AND, page and full erase.
// Updates happen on the commit pulse at the end of an operation.
// Assumes WORDS_PER_PAGE divides the array evenly; reset leaves it erased.
module nvm_word_array
    import nvm_prog_pkg::*;
#(
    parameter int NUM_WORDS      = 32,
    parameter int WORDS_PER_PAGE = 8,
    parameter int WIDX_W         = 5,
    parameter int PIDX_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  nvm_op_e           op,
    input  logic [WIDX_W-1:0] widx,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [31:0]       data,
    input  logic [WIDX_W-1:0] ridx,
    output logic [31:0]       rdata
);
    logic [31:0] mem [NUM_WORDS];

    // Apply the pending operation to the words it touches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (op == OP_ALL)
                    mem[i] <= '1;
                else if (op == OP_PAGE && (i / WORDS_PER_PAGE) == int'(pidx))
                    mem[i] <= '1;
                else if (op == OP_PROG && i == int'(widx))
                    mem[i] <= mem[i] & data;
            end
        end
    end

    // Combinational read port.
    always_comb rdata = mem[ridx];

    // R4
    prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_PROG) |=> (mem[$past(widx)] == ($past(mem[widx]) & $past(data))));
    // R7
    erase_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_ALL) |=> (mem[0] == '1 && mem[NUM_WORDS-1] == '1));
endmodule

// File: rtl/nvm_cmd_decode.sv
// Bus command decoder: mode register, sticky error flag, command gating
// and the operand latch held for the duration of an operation.
// Assumes NUM_WORDS < 2**(ADDR_W-1).
module nvm_cmd_decode
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_WORDS    = 32,
    parameter int NUM_PAGES    = 4,
    parameter int WIDX_W       = 5,
    parameter int PIDX_W       = 2,
    parameter int CNT_W        = 8,
    parameter int WRITE_CYCLES = 5,
    parameter int PAGE_CYCLES  = 12,
    parameter int ALL_CYCLES   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              busy,
    output logic [1:0]        mode,
    output logic              err,
    output logic              is_reg,
    output logic              word_in,
    output logic [WIDX_W-1:0] ridx,
    output logic              start,
    output logic [CNT_W-1:0]  dur,
    output nvm_op_e           op,
    output logic [WIDX_W-1:0] widx,
    output logic [PIDX_W-1:0] pidx,
    output logic [31:0]       data
);
    localparam logic [ADDR_W-2:0] NW_L = (ADDR_W-1)'(NUM_WORDS);
    localparam logic [31:0]       NP_L = 32'(NUM_PAGES);

    logic [1:0] roff;
    logic       wr, page_in, clr;
    logic       cmd_prog, cmd_page, cmd_all, cmd_mode;
    logic       ok_prog, ok_page, ok_all, ok_mode, bad;
    nvm_op_e    op_next;

    // Decode the bus access and decide which command is accepted.
    always_comb begin
        is_reg   = bus_addr[ADDR_W-1];
        roff     = bus_addr[1:0];
        word_in  = (bus_addr[ADDR_W-2:0] < NW_L);
        page_in  = (bus_wdata < NP_L);
        ridx     = bus_addr[WIDX_W-1:0];
        wr       = bus_req && bus_wr;
        cmd_prog = wr && !is_reg;
        cmd_mode = wr && is_reg && roff == REG_MODE;
        cmd_page = wr && is_reg && roff == REG_PAGE;
        cmd_all  = wr && is_reg && roff == REG_ALL;
        clr      = wr && is_reg && roff == REG_STAT && bus_wdata[1];
        ok_prog  = cmd_prog && !busy && mode == MODE_WEN && word_in;
        ok_page  = cmd_page && !busy && mode == MODE_EEN && page_in;
        ok_all   = cmd_all  && !busy && mode == MODE_EEN;
        ok_mode  = cmd_mode && !busy;
        bad      = (cmd_prog || cmd_page || cmd_all || cmd_mode)
                   && !(ok_prog || ok_page || ok_all || ok_mode);
        start    = ok_prog || ok_page || ok_all;
        op_next  = ok_prog ? OP_PROG : (ok_page ? OP_PAGE : OP_ALL);
        dur      = ok_prog ? CNT_W'(WRITE_CYCLES)
                 : (ok_page ? CNT_W'(PAGE_CYCLES) : CNT_W'(ALL_CYCLES));
    end

    // Mode register, written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= MODE_RO;
        else if (ok_mode) mode <= bus_wdata[1:0];
    end

    // Sticky error flag; a new fault wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   err <= 1'b0;
        else if (bad) err <= 1'b1;
        else if (clr) err <= 1'b0;
    end

    // Latch the operands of an accepted command for its whole duration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op   <= OP_PROG;
            widx <= '0;
            pidx <= '0;
            data <= '1;
        end else if (start) begin
            op   <= op_next;
            widx <= bus_addr[WIDX_W-1:0];
            pidx <= bus_wdata[PIDX_W-1:0];
            data <= bus_wdata;
        end
    end

    // R8
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R3
    prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_next == OP_PROG) |-> (mode == MODE_WEN));
    // R6
    erase_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_next != OP_PROG) |-> (mode == MODE_EEN));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));
endmodule

// File: rtl/nvm_prog_ctrl.sv
// Top of the flash program/erase controller: decoder, operation timer,
// word array and the read mux for the bus.
// Assumes a well-behaved requester honours bus_stall; stray commands are
// rejected and flagged.
module nvm_prog_ctrl
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int NUM_PAGES      = 4,
    parameter int WORDS_PER_PAGE = 8,
    parameter int WRITE_CYCLES   = 5,
    parameter int PAGE_CYCLES    = 12,
    parameter int ALL_CYCLES     = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_stall
);
    localparam int NUM_WORDS = NUM_PAGES * WORDS_PER_PAGE;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int PIDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int MAX_A     = (WRITE_CYCLES > PAGE_CYCLES) ? WRITE_CYCLES : PAGE_CYCLES;
    localparam int MAX_C     = (MAX_A > ALL_CYCLES) ? MAX_A : ALL_CYCLES;
    localparam int CNT_W     = $clog2(MAX_C + 1);

    logic [1:0]        mode;
    logic              err, is_reg, word_in, start, busy, done;
    logic [CNT_W-1:0]  dur;
    nvm_op_e           op;
    logic [WIDX_W-1:0] ridx, widx;
    logic [PIDX_W-1:0] pidx;
    logic [31:0]       data, arr_rdata;

    nvm_cmd_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .NUM_PAGES(NUM_PAGES),
        .WIDX_W(WIDX_W), .PIDX_W(PIDX_W), .CNT_W(CNT_W),
        .WRITE_CYCLES(WRITE_CYCLES), .PAGE_CYCLES(PAGE_CYCLES), .ALL_CYCLES(ALL_CYCLES)
    ) dec_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
        .mode(mode), .err(err), .is_reg(is_reg), .word_in(word_in), .ridx(ridx),
        .start(start), .dur(dur), .op(op), .widx(widx), .pidx(pidx), .data(data)
    );

    nvm_op_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dur(dur), .busy(busy), .done(done)
    );

    nvm_word_array #(
        .NUM_WORDS(NUM_WORDS), .WORDS_PER_PAGE(WORDS_PER_PAGE),
        .WIDX_W(WIDX_W), .PIDX_W(PIDX_W)
    ) arr_i (
        .clk(clk), .rst_n(rst_n), .commit(done), .op(op), .widx(widx), .pidx(pidx),
        .data(data), .ridx(ridx), .rdata(arr_rdata)
    );

    // Read mux and stall output.
    always_comb begin
        bus_stall = busy;
        if (is_reg) begin
            case (bus_addr[1:0])
                REG_MODE: bus_rdata = {30'd0, mode};
                REG_STAT: bus_rdata = {30'd0, err, !busy};
                default:  bus_rdata = 32'd0;
            endcase
        end else begin
            bus_rdata = word_in ? arr_rdata : 32'd0;
        end
    end

    // R11
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_stall |-> !done);
    // R5
    start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> bus_stall);
endmodule

// File: tb/nvm_prog_ctrl_tb.sv
// Directed bench for the flash program/erase controller.
module nvm_prog_ctrl_tb_top;
    localparam int WC = 5, PC = 12, AC = 30;
    localparam logic [7:0] A_MODE = 8'h80, A_STAT = 8'h81, A_PAGE = 8'h82, A_ALL = 8'h83;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_stall;
    int          checks = 0, errors = 0, cyc = 0;

    nvm_prog_ctrl #(.ADDR_W(8), .NUM_PAGES(4), .WORDS_PER_PAGE(8),
        .WRITE_CYCLES(WC), .PAGE_CYCLES(PC), .ALL_CYCLES(AC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_stall(bus_stall));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (bus_stall) begin n++; @(negedge clk); end
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic clear_err();
        wr(A_STAT, 32'h2);
    endtask

    task automatic t_reset();
        expect_rd("R1 mode", A_MODE, 32'd0);
        expect_rd("R1 status", A_STAT, 32'd1);
        chk("R1 stall", {31'd0, bus_stall}, 32'd0);
        expect_rd("R1 word0", 8'd0, 32'hFFFF_FFFF);
        expect_rd("R1 word31", 8'd31, 32'hFFFF_FFFF);
    endtask

    task automatic t_mode();
        wr(A_MODE, 32'd1);
        expect_rd("R2 mode=1", A_MODE, 32'd1);
        wr(A_MODE, 32'd3);
        expect_rd("R2 mode=3", A_MODE, 32'd3);
        wr(8'd2, 32'd0);
        chk("R2 no op in mode 3", {31'd0, bus_stall}, 32'd0);
        expect_rd("R2 word2 kept", 8'd2, 32'hFFFF_FFFF);
        expect_rd("R2 err set", A_STAT, 32'd3);
        clear_err();
        expect_rd("R10 err cleared", A_STAT, 32'd1);
    endtask

    task automatic t_write_gate();
        wr(A_MODE, 32'd0);
        wr(8'd1, 32'd0);
        chk("R3 ro no op", {31'd0, bus_stall}, 32'd0);
        expect_rd("R3 ro err", A_STAT, 32'd3);
        clear_err();
        wr(A_MODE, 32'd2);
        wr(8'd1, 32'd0);
        chk("R3 erase-mode no op", {31'd0, bus_stall}, 32'd0);
        expect_rd("R3 word1 kept", 8'd1, 32'hFFFF_FFFF);
        expect_rd("R3 een err", A_STAT, 32'd3);
        clear_err();
    endtask

    task automatic t_program();
        int n;
        wr(A_MODE, 32'd1);
        wr(8'd3, 32'hF0F0_00FF);
        expect_rd("R5 ready low", A_STAT, 32'd0);
        chk("R11 stall high", {31'd0, bus_stall}, 32'd1);
        wait_idle(n);
        chk("R5 write length", n, WC);
        expect_rd("R11 ready back", A_STAT, 32'd1);
        expect_rd("R4 first write", 8'd3, 32'hF0F0_00FF);
        wr(8'd3, 32'h0FFF_0F0F);
        wait_idle(n);
        expect_rd("R4 and result", 8'd3, 32'h00F0_000F);
        wr(8'd3, 32'hFFFF_FFFF);
        wait_idle(n);
        expect_rd("R4 ones no change", 8'd3, 32'h00F0_000F);
        expect_rd("R4 neighbour", 8'd4, 32'hFFFF_FFFF);
    endtask

    task automatic t_busy();
        int n;
        wr(8'd5, 32'd0);
        wr(8'd6, 32'd0);
        wr(A_MODE, 32'd2);
        wait_idle(n);
        chk("R5 remaining length", n, WC - 2);
        expect_rd("R8 mode kept", A_MODE, 32'd1);
        expect_rd("R8 word6 kept", 8'd6, 32'hFFFF_FFFF);
        expect_rd("R8 word5 written", 8'd5, 32'd0);
        expect_rd("R8 err", A_STAT, 32'd3);
        clear_err();
    endtask

    task automatic t_range();
        wr(8'd32, 32'd0);
        chk("R9 word range no op", {31'd0, bus_stall}, 32'd0);
        expect_rd("R9 word range err", A_STAT, 32'd3);
        clear_err();
        wr(A_MODE, 32'd2);
        wr(A_PAGE, 32'd4);
        chk("R9 page range no op", {31'd0, bus_stall}, 32'd0);
        expect_rd("R9 page range err", A_STAT, 32'd3);
        clear_err();
    endtask

    task automatic t_page();
        int n;
        wr(A_MODE, 32'd1);
        wr(8'd8, 32'd0);  wait_idle(n);
        wr(8'd15, 32'd0); wait_idle(n);
        wr(8'd16, 32'd0); wait_idle(n);
        wr(A_PAGE, 32'd1);
        chk("R6 wrong mode no op", {31'd0, bus_stall}, 32'd0);
        expect_rd("R6 wrong mode err", A_STAT, 32'd3);
        expect_rd("R6 word8 kept", 8'd8, 32'd0);
        clear_err();
        wr(A_MODE, 32'd2);
        wr(A_PAGE, 32'd1);
        wait_idle(n);
        chk("R5 page length", n, PC);
        expect_rd("R6 word8 erased", 8'd8, 32'hFFFF_FFFF);
        expect_rd("R6 word15 erased", 8'd15, 32'hFFFF_FFFF);
        expect_rd("R6 word16 kept", 8'd16, 32'd0);
        expect_rd("R6 word3 kept", 8'd3, 32'h00F0_000F);
    endtask

    task automatic t_all();
        int n;
        wr(A_MODE, 32'd1);
        wr(A_ALL, 32'd0);
        chk("R7 wrong mode no op", {31'd0, bus_stall}, 32'd0);
        expect_rd("R7 wrong mode err", A_STAT, 32'd3);
        expect_rd("R7 word16 kept", 8'd16, 32'd0);
        clear_err();
        wr(A_MODE, 32'd2);
        wr(A_ALL, 32'd0);
        wait_idle(n);
        chk("R5 erase-all length", n, AC);
        expect_rd("R7 word3", 8'd3, 32'hFFFF_FFFF);
        expect_rd("R7 word5", 8'd5, 32'hFFFF_FFFF);
        expect_rd("R7 word16", 8'd16, 32'hFFFF_FFFF);
    endtask

    task automatic t_err();
        int n;
        wr(A_MODE, 32'd0);
        wr(A_ALL, 32'd0);
        wr(A_STAT, 32'h1);
        expect_rd("R10 zero write keeps", A_STAT, 32'd3);
        wr(A_MODE, 32'd1);
        wr(8'd0, 32'h1234_5678);
        wait_idle(n);
        expect_rd("R10 kept over op", A_STAT, 32'd3);
        wr(A_STAT, 32'h2);
        expect_rd("R10 one clears", A_STAT, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_write_gate();
        t_program();
        t_busy();
        t_range();
        t_page();
        t_all();
        t_err();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule